// File: doc/BRIEF.md
# Indirect Codec Register Access Sequencer

This block lets a host reach the internal registers of an audio codec that exposes only two byte-wide direct registers: a command register that selects an internal register, and a data register that moves its contents. A single host request (register number, write data, width, direction) becomes a short series of direct accesses on the codec port. The first access always writes the register number to the command register. After that come one or two data-register transfers.

Sixteen-bit values are not symmetric. A wide write sends the low byte first. A wide read treats the first byte returned as the high byte. A static bus-variant strap selects how direct registers map onto the 32-bit codec port. In the narrow-lane variant, register N is at byte offset N×64 and the byte travels on bits 7:0. In the wide-lane variant, register N is at offset N×4 and the byte travels on bits 15:8.

Each codec access holds its strobe until the codec acknowledges. A watchdog counter ends a stalled sequence and reports an error.

Top module: `codec_ireg_seq`

## Requirements
- R1: After synchronous active-low reset, req_ready is 1, and bus_strobe, rsp_done and rsp_err are 0.
- R2: Every accepted request starts with one direct write of the register number to the command register (direct index 0).
- R3: An 8-bit write follows the command write with exactly one write of req_wdata[7:0] to the data register (direct index 1).
- R4: A 16-bit write follows the command write with two data-register writes: req_wdata[7:0] first, then req_wdata[15:8].
- R5: An 8-bit read follows the command write with one data-register read. The byte returned appears on rsp_rdata[7:0], and rsp_rdata[15:8] is 0.
- R6: A 16-bit read does two data-register reads. The first byte goes to rsp_rdata[15:8] and the second to rsp_rdata[7:0].
- R7: With lane_mode = 0, direct index N is at bus_addr = N×64. Write data sits on bus_wdata[7:0] with all other bits 0. Read data is taken from bus_rdata[7:0].
- R8: With lane_mode = 1, direct index N is at bus_addr = N×4. Write data sits on bus_wdata[15:8] with all other bits 0. Read data is taken from bus_rdata[15:8].
- R9: bus_strobe stays high with a stable address until bus_ack is seen. An access completes in the cycle in which bus_ack is high, so an access with k wait cycles keeps the strobe high for k+1 cycles.
- R10: req_ready is 0 from acceptance until the sequence ends. A request presented while req_ready is 0 is ignored and produces no codec accesses.
- R11: If bus_ack does not arrive within TIMEOUT strobe cycles of one access, the sequence aborts. The strobe is high for exactly TIMEOUT cycles, no further access follows, and rsp_done pulses with rsp_err = 1.
- R12: rsp_done is a one-cycle pulse. rsp_rdata and rsp_err are valid with it, and req_ready returns to 1 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lane_mode | input | 1 | Bus-variant strap: 0 narrow lane (×64, bits 7:0), 1 wide lane (×4, bits 15:8) |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Sequencer idle and able to accept |
| req_reg | input | REG_W | Internal codec register number |
| req_wdata | input | 16 | Write data (low byte used for 8-bit writes) |
| req_wide | input | 1 | 1 = 16-bit access, 0 = 8-bit |
| req_write | input | 1 | 1 = write, 0 = read |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read result |
| rsp_err | output | 1 | Sequence aborted by timeout |
| bus_addr | output | ADDR_W | Direct-register byte offset |
| bus_wdata | output | 32 | Direct write data |
| bus_rdata | input | 32 | Direct read data |
| bus_we | output | 1 | Direct access is a write |
| bus_strobe | output | 1 | Direct access request |
| bus_ack | input | 1 | Codec acknowledge |

## Verification
The hardest case to reach is the busy-time hazard. A second request has to arrive while an earlier sequence is still in flight, and that earlier sequence has to be either stretched by codec wait states or stalled until the watchdog fires. The bench's codec model has a programmable acknowledge delay and a switch that suppresses acknowledges. Using these, the bench holds a conflicting request on the host port during a slowed sequence, and it lets a sequence run into the timeout. In both cases it then checks the logged direct accesses, the strobe-cycle count, the result, and a normal request issued afterwards.

// File: rtl/codec_seq_pkg.sv
// Package: shared types for the indirect codec register sequencer.
// Assumes nothing beyond standard SystemVerilog.
package codec_seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_CMD  = 3'd1,
        ST_DAT1 = 3'd2,
        ST_DAT2 = 3'd3,
        ST_DONE = 3'd4
    } seq_state_t;

    localparam int DATA_BYTES = 2;
endpackage

// File: rtl/ireg_ack_timer.sv
// Module: ireg_ack_timer
// Counts cycles that a direct access waits for its acknowledge.
// Asserts expired in the LIMIT-th waiting cycle of one access.
// Assumes armed stays high across back-to-back accesses; ack restarts the count.
module ireg_ack_timer #(
    parameter int LIMIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic armed,
    input  logic ack,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    // Wait-cycle counter, cleared whenever no access is waiting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!armed || ack || expired) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // Expiry decode for the final allowed wait cycle.
    always_comb begin
        expired = armed && !ack && (cnt == CW'(LIMIT - 1));
    end

    // R11
    cnt_below_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < CW'(LIMIT));
endmodule

// File: rtl/ireg_lane_map.sv
// Module: ireg_lane_map
// Maps a direct-register index and byte onto the 32-bit codec port,
// according to the bus-variant strap. Purely combinational.
// Assumes lane_mode is static while a sequence runs.
module ireg_lane_map #(
    parameter int DIR_W        = 2,
    parameter int SHIFT_NARROW = 6,
    parameter int SHIFT_WIDE   = 2,
    parameter int ADDR_W       = DIR_W + SHIFT_NARROW
) (
    input  logic              lane_mode,
    input  logic [DIR_W-1:0]  dir_idx,
    input  logic [7:0]        byte_out,
    input  logic [31:0]       port_rdata,
    output logic [ADDR_W-1:0] port_addr,
    output logic [31:0]       port_wdata,
    output logic [7:0]        byte_in
);
    localparam int LANE_NARROW = 0;
    localparam int LANE_WIDE   = 8;

    logic [ADDR_W-1:0] idx_ext;

    // Widen the index before scaling.
    always_comb begin
        idx_ext = ADDR_W'(dir_idx);
    end

    // Address scaling and byte-lane placement per strap.
    always_comb begin
        if (lane_mode) begin
            port_addr  = idx_ext << SHIFT_WIDE;
            port_wdata = 32'(byte_out) << LANE_WIDE;
            byte_in    = port_rdata[LANE_WIDE +: 8];
        end else begin
            port_addr  = idx_ext << SHIFT_NARROW;
            port_wdata = 32'(byte_out) << LANE_NARROW;
            byte_in    = port_rdata[LANE_NARROW +: 8];
        end
    end
endmodule

// File: rtl/ireg_seq_fsm.sv
// Module: ireg_seq_fsm
// Steps one host request through command write, one or two data
// transfers, and a done cycle. Wide writes send the low byte first.
// Wide reads place the first byte returned in the high half.
// Assumes the timer raises expired only while an access is waiting.
module ireg_seq_fsm
    import codec_seq_pkg::*;
#(
    parameter int REG_W    = 8,
    parameter int DIR_W    = 2,
    parameter int CMD_IDX  = 0,
    parameter int DATA_IDX = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [REG_W-1:0] req_reg,
    input  logic [15:0]      req_wdata,
    input  logic             req_wide,
    input  logic             req_write,
    output logic             req_ready,
    output logic             rsp_done,
    output logic [15:0]      rsp_rdata,
    output logic             rsp_err,
    output logic [DIR_W-1:0] acc_idx,
    output logic [7:0]       acc_byte,
    output logic             acc_we,
    output logic             acc_strobe,
    input  logic             acc_ack,
    input  logic [7:0]       acc_rbyte,
    input  logic             expired
);
    seq_state_t       state;
    logic [REG_W-1:0] reg_q;
    logic [15:0]      wdata_q;
    logic             wide_q;
    logic             write_q;
    logic [15:0]      rdata_q;
    logic             err_q;

    // Sequencer state and request capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            reg_q   <= '0;
            wdata_q <= '0;
            wide_q  <= 1'b0;
            write_q <= 1'b0;
            rdata_q <= '0;
            err_q   <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        reg_q   <= req_reg;
                        wdata_q <= req_wdata;
                        wide_q  <= req_wide;
                        write_q <= req_write;
                        rdata_q <= '0;
                        err_q   <= 1'b0;
                        state   <= ST_CMD;
                    end
                end
                ST_CMD: begin
                    if (acc_ack) begin
                        state <= ST_DAT1;
                    end else if (expired) begin
                        err_q <= 1'b1;
                        state <= ST_DONE;
                    end
                end
                ST_DAT1: begin
                    if (acc_ack) begin
                        if (!write_q) begin
                            if (wide_q) rdata_q[15:8] <= acc_rbyte;
                            else        rdata_q[7:0]  <= acc_rbyte;
                        end
                        state <= wide_q ? ST_DAT2 : ST_DONE;
                    end else if (expired) begin
                        err_q <= 1'b1;
                        state <= ST_DONE;
                    end
                end
                ST_DAT2: begin
                    if (acc_ack) begin
                        if (!write_q) rdata_q[7:0] <= acc_rbyte;
                        state <= ST_DONE;
                    end else if (expired) begin
                        err_q <= 1'b1;
                        state <= ST_DONE;
                    end
                end
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Direct-access request fields for the current step.
    always_comb begin
        acc_strobe = (state == ST_CMD) || (state == ST_DAT1) || (state == ST_DAT2);
        acc_idx    = (state == ST_CMD) ? DIR_W'(CMD_IDX) : DIR_W'(DATA_IDX);
        acc_we     = (state == ST_CMD) || write_q;
        case (state)
            ST_CMD:  acc_byte = 8'(reg_q);
            ST_DAT1: acc_byte = wdata_q[7:0];
            ST_DAT2: acc_byte = wdata_q[15:8];
            default: acc_byte = 8'h00;
        endcase
    end

    // Host-side handshake and response.
    always_comb begin
        req_ready = (state == ST_IDLE);
        rsp_done  = (state == ST_DONE);
        rsp_rdata = rdata_q;
        rsp_err   = err_q;
    end

    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> (!rsp_done && req_ready));
endmodule

// File: rtl/codec_ireg_seq.sv
// Module: codec_ireg_seq (top)
// Turns host 8/16-bit indirect register requests into direct accesses on
// a codec's command/data register pair, with acknowledge wait and timeout.
// Assumes lane_mode is a static strap and REG_W is at most 8.
module codec_ireg_seq #(
    parameter int REG_W        = 8,
    parameter int DIR_W        = 2,
    parameter int CMD_IDX      = 0,
    parameter int DATA_IDX     = 1,
    parameter int SHIFT_NARROW = 6,
    parameter int SHIFT_WIDE   = 2,
    parameter int TIMEOUT      = 64,
    parameter int ADDR_W       = DIR_W + SHIFT_NARROW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lane_mode,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [REG_W-1:0]  req_reg,
    input  logic [15:0]       req_wdata,
    input  logic              req_wide,
    input  logic              req_write,
    output logic              rsp_done,
    output logic [15:0]       rsp_rdata,
    output logic              rsp_err,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [31:0]       bus_wdata,
    input  logic [31:0]       bus_rdata,
    output logic              bus_we,
    output logic              bus_strobe,
    input  logic              bus_ack
);
    logic [DIR_W-1:0] acc_idx;
    logic [7:0]       acc_byte;
    logic [7:0]       acc_rbyte;
    logic             expired;

    ireg_seq_fsm #(
        .REG_W(REG_W), .DIR_W(DIR_W), .CMD_IDX(CMD_IDX), .DATA_IDX(DATA_IDX)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_reg(req_reg), .req_wdata(req_wdata),
        .req_wide(req_wide), .req_write(req_write), .req_ready(req_ready),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
        .acc_idx(acc_idx), .acc_byte(acc_byte), .acc_we(bus_we),
        .acc_strobe(bus_strobe), .acc_ack(bus_ack), .acc_rbyte(acc_rbyte),
        .expired(expired)
    );

    ireg_lane_map #(
        .DIR_W(DIR_W), .SHIFT_NARROW(SHIFT_NARROW), .SHIFT_WIDE(SHIFT_WIDE),
        .ADDR_W(ADDR_W)
    ) u_map (
        .lane_mode(lane_mode), .dir_idx(acc_idx), .byte_out(acc_byte),
        .port_rdata(bus_rdata), .port_addr(bus_addr), .port_wdata(bus_wdata),
        .byte_in(acc_rbyte)
    );

    ireg_ack_timer #(.LIMIT(TIMEOUT)) u_timer (
        .clk(clk), .rst_n(rst_n), .armed(bus_strobe), .ack(bus_ack),
        .expired(expired)
    );

    // R2
    first_access_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_strobe) |-> bus_we);

    // R9
    strobe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_strobe && !bus_ack && !expired) |=> (bus_strobe && $stable(bus_addr)));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !bus_strobe);

    // R11
    err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rsp_err) |-> rsp_done);
endmodule

// File: tb/test_codec_ireg_seq.sv
module test_codec_ireg_seq;
    localparam int TMO    = 8;
    localparam int ADDR_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              lane_mode = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [7:0]        req_reg = '0;
    logic [15:0]       req_wdata = '0;
    logic              req_wide = 1'b0;
    logic              req_write = 1'b0;
    logic              rsp_done;
    logic [15:0]       rsp_rdata;
    logic              rsp_err;
    logic [ADDR_W-1:0] bus_addr;
    logic [31:0]       bus_wdata;
    logic [31:0]       bus_rdata = '0;
    logic              bus_we;
    logic              bus_strobe;
    logic              bus_ack = 1'b0;

    codec_ireg_seq #(.TIMEOUT(TMO)) i_codec_ireg_seq (
        .clk(clk), .rst_n(rst_n), .lane_mode(lane_mode),
        .req_valid(req_valid), .req_ready(req_ready), .req_reg(req_reg),
        .req_wdata(req_wdata), .req_wide(req_wide), .req_write(req_write),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_we(bus_we), .bus_strobe(bus_strobe), .bus_ack(bus_ack)
    );

    always #5 clk = ~clk;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // codec model state
    int          ack_delay = 0;
    bit          ack_en = 1;
    int          wcnt = 0;
    int          log_n = 0;
    int          strobe_cycles = 0;
    logic [ADDR_W-1:0] log_addr [0:7];
    logic [31:0] log_wdata [0:7];
    logic        log_we [0:7];
    logic [7:0]  rd_bytes [0:3];
    int          rd_ptr = 0;
    logic [15:0] got_rdata;
    logic        got_err;

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Codec model: acknowledges after ack_delay wait cycles and logs accesses.
    always @(negedge clk) begin
        bus_ack = 1'b0;
        if (rst_n && bus_strobe) begin
            strobe_cycles++;
            if (ack_en && wcnt >= ack_delay) begin
                wcnt = 0;
                if (log_n < 8) begin
                    log_addr[log_n]  = bus_addr;
                    log_wdata[log_n] = bus_wdata;
                    log_we[log_n]    = bus_we;
                end
                log_n++;
                if (!bus_we) begin
                    if (lane_mode) bus_rdata = {16'h5A5A, rd_bytes[rd_ptr], 8'h3C};
                    else           bus_rdata = {24'hC3C3C3, rd_bytes[rd_ptr]};
                    rd_ptr++;
                end
                bus_ack = 1'b1;
            end else begin
                wcnt++;
            end
        end else begin
            wcnt = 0;
        end
    end

    function automatic logic [ADDR_W-1:0] exp_addr(input int idx);
        return lane_mode ? ADDR_W'(idx * 4) : ADDR_W'(idx * 64);
    endfunction

    function automatic logic [31:0] exp_wd(input logic [7:0] b);
        return lane_mode ? {16'h0, b, 8'h0} : {24'h0, b};
    endfunction

    task automatic start_op(input bit wr, input bit wide, input logic [7:0] rg,
                            input logic [15:0] wd);
        log_n = 0; rd_ptr = 0; strobe_cycles = 0;
        req_valid = 1'b1; req_write = wr; req_wide = wide; req_reg = rg; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_done(input string tag);
        bit seen = 0;
        for (int i = 0; i < 200; i++) begin
            if (rsp_done) begin
                seen = 1;
                got_rdata = rsp_rdata;
                got_err = rsp_err;
                break;
            end
            @(negedge clk);
        end
        check(seen, {tag, " done seen"}, 32'(seen), 32'd1);
        @(negedge clk);
        // R12: one-cycle pulse and ready again
        check(!rsp_done && req_ready, "R12 done pulse one cycle", 32'(rsp_done), 32'd0);
    endtask

    task automatic check_cmd(input logic [7:0] rg, input string tag);
        check(log_we[0] == 1'b1 && log_addr[0] == exp_addr(0), {tag, " R2 cmd addr"},
              32'(log_addr[0]), 32'(exp_addr(0)));
        check(log_wdata[0] == exp_wd(rg), {tag, " R2 cmd data"}, log_wdata[0], exp_wd(rg));
    endtask

    task automatic t_reset;
        @(negedge clk);
        check(req_ready == 1'b1, "R1 ready after reset", 32'(req_ready), 32'd1);
        check(bus_strobe == 1'b0, "R1 strobe after reset", 32'(bus_strobe), 32'd0);
        check(rsp_done == 1'b0 && rsp_err == 1'b0, "R1 done/err after reset",
              {30'd0, rsp_done, rsp_err}, 32'd0);
    endtask

    task automatic t_write8(input logic [7:0] rg, input logic [7:0] v, input string tag);
        start_op(1, 0, rg, {8'hEE, v});
        wait_done(tag);
        check(log_n == 2, {tag, " R3 access count"}, 32'(log_n), 32'd2);
        check_cmd(rg, tag);
        check(log_we[1] && log_addr[1] == exp_addr(1), {tag, " R3 data addr (R7/R8)"},
              32'(log_addr[1]), 32'(exp_addr(1)));
        check(log_wdata[1] == exp_wd(v), {tag, " R3 data value (R7/R8)"},
              log_wdata[1], exp_wd(v));
    endtask

    task automatic t_write16(input logic [7:0] rg, input logic [15:0] v, input string tag);
        start_op(1, 1, rg, v);
        wait_done(tag);
        check(log_n == 3, {tag, " R4 access count"}, 32'(log_n), 32'd3);
        check_cmd(rg, tag);
        check(log_wdata[1] == exp_wd(v[7:0]) && log_addr[1] == exp_addr(1),
              {tag, " R4 low byte first"}, log_wdata[1], exp_wd(v[7:0]));
        check(log_wdata[2] == exp_wd(v[15:8]) && log_addr[2] == exp_addr(1),
              {tag, " R4 high byte second"}, log_wdata[2], exp_wd(v[15:8]));
    endtask

    task automatic t_read8(input logic [7:0] rg, input logic [7:0] b, input string tag);
        rd_bytes[0] = b;
        start_op(0, 0, rg, 16'hFFFF);
        wait_done(tag);
        check(log_n == 2 && !log_we[1] && log_addr[1] == exp_addr(1),
              {tag, " R5 one data read"}, 32'(log_n), 32'd2);
        check_cmd(rg, tag);
        check(got_rdata == {8'h00, b} && !got_err, {tag, " R5 read value"},
              32'(got_rdata), {24'd0, b});
    endtask

    task automatic t_read16(input logic [7:0] rg, input logic [7:0] b0, input logic [7:0] b1,
                            input string tag);
        rd_bytes[0] = b0; rd_bytes[1] = b1;
        start_op(0, 1, rg, 16'h0);
        wait_done(tag);
        check(log_n == 3 && !log_we[1] && !log_we[2], {tag, " R6 two data reads"},
              32'(log_n), 32'd3);
        check(got_rdata == {b0, b1}, {tag, " R6 first byte high"},
              32'(got_rdata), {16'd0, b0, b1});
    endtask

    task automatic t_slow_ack;
        ack_delay = 3;
        rd_bytes[0] = 8'h81; rd_bytes[1] = 8'h42;
        start_op(0, 1, 8'h17, 16'h0);
        wait_done("slow");
        // R9: three accesses, each held delay+1 cycles
        check(strobe_cycles == 12, "R9 strobe held until ack", 32'(strobe_cycles), 32'd12);
        check(got_rdata == 16'h8142 && log_n == 3, "R9 data with wait states",
              32'(got_rdata), 32'h8142);
        ack_delay = 0;
    endtask

    task automatic t_busy_ignore;
        bit ready_low = 1;
        ack_delay = 2;
        start_op(1, 0, 8'h21, 16'h0033);
        req_valid = 1'b1; req_write = 1'b1; req_wide = 1'b1; req_reg = 8'h99;
        req_wdata = 16'hBEEF;
        for (int i = 0; i < 3; i++) begin
            if (req_ready) ready_low = 0;
            @(negedge clk);
        end
        req_valid = 1'b0;
        check(ready_low, "R10 ready low while busy", 32'(ready_low), 32'd1);
        wait_done("busy");
        check(log_n == 2 && log_wdata[0] == exp_wd(8'h21) && log_wdata[1] == exp_wd(8'h33),
              "R10 busy request ignored", 32'(log_n), 32'd2);
        for (int i = 0; i < 4; i++) @(negedge clk);
        check(log_n == 2 && !bus_strobe, "R10 no later access", 32'(log_n), 32'd2);
        ack_delay = 0;
    endtask

    task automatic t_timeout;
        ack_en = 0;
        start_op(1, 1, 8'h05, 16'h1234);
        wait_done("timeout");
        check(got_err == 1'b1, "R11 error flag", 32'(got_err), 32'd1);
        check(strobe_cycles == TMO, "R11 strobe cycles before abort",
              32'(strobe_cycles), 32'(TMO));
        check(log_n == 0, "R11 no access completed", 32'(log_n), 32'd0);
        ack_en = 1;
        t_write8(8'h06, 8'h77, "after-timeout R11");
        check(got_err == 1'b0, "R11 error cleared on next request", 32'(got_err), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        lane_mode = 1'b0;
        t_write8(8'h2A, 8'hC5, "m0 w8 R7");
        t_write16(8'h13, 16'hA55A, "m0 w16 R7");
        t_read8(8'h40, 8'h9D, "m0 r8 R7");
        t_read16(8'h41, 8'hB7, 8'h0E, "m0 r16 R7");
        lane_mode = 1'b1;
        t_write8(8'h3F, 8'h6B, "m1 w8 R8");
        t_write16(8'h08, 16'h1FE2, "m1 w16 R8");
        t_read8(8'h55, 8'hE4, "m1 r8 R8");
        t_read16(8'h7C, 8'h01, 8'hFE, "m1 r16 R8");
        lane_mode = 1'b0;
        t_slow_ack();
        t_busy_ignore();
        t_timeout();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(200000 * 10);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule